// File: doc/BRIEF.md
# Tag Memory With Registered Compare

This block is a small synchronous tag store built for cache lookup logic. Each word is 18 bits wide and is split into two 9-bit lanes. A sequencer outside the block presents an address on every clock. The block returns the stored word one clock later. In the same cycle it reports whether that word equals the tag held in a separately enabled input register.

That input register has two jobs. It supplies the tag for the comparison, and it also supplies the data for every write. A full-word write control stores both lanes, and it takes priority over the lane controls. When the full-word write is idle, a byte-write gate qualifies two lane enables, so each lane can be written on its own. A read in the same cycle as a write to the same address returns the new word, so a compare in the cycle after a write already sees what was written.

Two asynchronous enables gate the outputs. The data-valid flag drops when the output enable is off or when any write is under way; it stands in for the output drivers going to high impedance. The match flag is forced low while the match enable is off.

Top module: `tag_match_ram`

## Requirements
- R1: While reset is asserted, and after it is released until the first clock edge, `dout` is 0 and `match` is 0.
- R2: The input tag register loads `din` on a clock edge only when `din_en_n` is 0. When `din_en_n` is 1 it keeps its value, whatever `din` is.
- R3: When `gw_n` is 0 on a clock edge, all 18 bits at `addr` take the input tag register's value, regardless of `bw_n` and `lane_we_n`.
- R4: When `gw_n` is 1 and `bw_n` is 0, `lane_we_n[0]`=0 writes bits 8:0 and `lane_we_n[1]`=0 writes bits 17:9 from the input tag register. A lane whose enable is 1 keeps its old contents.
- R5: When `gw_n` and `bw_n` are both 1, `lane_we_n` has no effect and the memory is unchanged.
- R6: `dout` shows, after clock edge k, the word stored at the `addr` presented at edge k.
- R7: If edge k writes the presented address, `dout` after edge k shows the newly written word, not the old one.
- R8: After edge k, the registered match is 1 exactly when the input tag register's value before edge k equals the word shown on `dout`.
- R9: `match` is 0 whenever `moe_n` is 1, with no clock edge needed. When `moe_n` is 0, `match` shows the registered match.
- R10: `dout_valid` is 0 whenever `oe_n` is 1, `gw_n` is 0, or `bw_n` is 0 with any bit of `lane_we_n` at 0. It is 1 otherwise. This follows the inputs without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Word address from the external sequencer |
| din | input | 18 | Tag/data input |
| din_en_n | input | 1 | Active-low load enable of the input tag register |
| gw_n | input | 1 | Active-low full-word write |
| bw_n | input | 1 | Active-low byte-write gate |
| lane_we_n | input | 2 | Active-low lane write enables; bit 0 is the low lane, bit 1 the high lane |
| oe_n | input | 1 | Asynchronous active-low output enable |
| moe_n | input | 1 | Asynchronous active-low match enable |
| dout | output | 18 | Registered read word |
| dout_valid | output | 1 | Data outputs enabled (0 stands for high impedance) |
| match | output | 1 | Tag equals stored word |

## Verification
The bench goes after the following corner cases, each of which a faulty design would get wrong in a visible way:
- Lane writes done one lane at a time. If the lanes were swapped or merged wrongly, the word would be half-corrupted and `match` would fail to rise.
- Lane enables applied while the byte gate is off. A design that ignored the gate would overwrite a word that must stay unchanged.
- A full-word write issued together with lane enables that are all off. A design that let the lane enables win over the full-word write would leave the word unwritten.
- A read in the same cycle as a write to the same address. Without the read bypass, the old word would appear on `dout`.
- Garbage on `din` while the tag load enable is off. A design that loaded the tag register anyway would store the wrong value at the next write.
- The two asynchronous enables. A design that registered either of them would lag the input by one cycle.

// File: rtl/tag_ram_pkg.sv
package tag_ram_pkg;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_LANE = 2'd1,
    WR_FULL = 2'd2
  } wr_kind_e;

endpackage

// File: rtl/tag_wr_ctl.sv
module tag_wr_ctl
  import tag_ram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] lane_we_n,
  output logic [LANES-1:0] lane_mask,
  output logic             wr_any,
  output wr_kind_e         wr_kind
);

  always_comb begin
    if (!gw_n) begin
      wr_kind   = WR_FULL;
      lane_mask = '1;
    end else if (!bw_n && (lane_we_n != '1)) begin
      wr_kind   = WR_LANE;
      lane_mask = ~lane_we_n;
    end else begin
      wr_kind   = WR_IDLE;
      lane_mask = '0;
    end
  end

  assign wr_any = (wr_kind != WR_IDLE);

endmodule

// File: rtl/tag_store.sv
module tag_store #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int DEPTH  = 16,
  localparam int WORD_W = LANE_W * LANES,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_mask,
  output logic [WORD_W-1:0] rd_word
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_mask[g]) begin
        mem[addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    // write-first bypass: a lane being written returns the new data
    assign rd_word[g*LANE_W +: LANE_W] =
      lane_mask[g] ? wdata[g*LANE_W +: LANE_W] : mem[addr];
  end

endmodule

// File: rtl/tag_cmp.sv
module tag_cmp #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic [WORD_W-1:0] tag_a,
  input  logic [WORD_W-1:0] tag_b,
  output logic              equal
);

  logic [LANES-1:0] lane_eq;

  for (genvar g = 0; g < LANES; g++) begin : g_eq
    assign lane_eq[g] = (tag_a[g*LANE_W +: LANE_W] == tag_b[g*LANE_W +: LANE_W]);
  end

  assign equal = &lane_eq;

endmodule

// File: rtl/tag_match_ram.sv
module tag_match_ram
  import tag_ram_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int DEPTH  = 16,
  localparam int WORD_W = LANE_W * LANES,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] din,
  input  logic              din_en_n,
  input  logic              gw_n,
  input  logic              bw_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              oe_n,
  input  logic              moe_n,
  output logic [WORD_W-1:0] dout,
  output logic              dout_valid,
  output logic              match
);

  logic [WORD_W-1:0] dreg_q, dreg_d;
  logic [WORD_W-1:0] rd_q, rd_d;
  logic              match_q, match_d;
  logic [WORD_W-1:0] rd_word;
  logic [LANES-1:0]  lane_mask;
  logic              wr_any;
  logic              tag_eq;
  wr_kind_e          wr_kind;

  tag_wr_ctl #(.LANES(LANES)) u_wr_ctl (
    .gw_n      (gw_n),
    .bw_n      (bw_n),
    .lane_we_n (lane_we_n),
    .lane_mask (lane_mask),
    .wr_any    (wr_any),
    .wr_kind   (wr_kind)
  );

  tag_store #(.LANE_W(LANE_W), .LANES(LANES), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .addr      (addr),
    .wdata     (dreg_q),
    .lane_mask (lane_mask),
    .rd_word   (rd_word)
  );

  tag_cmp #(.LANE_W(LANE_W), .LANES(LANES)) u_cmp (
    .tag_a (dreg_q),
    .tag_b (rd_word),
    .equal (tag_eq)
  );

  // next-state
  always_comb begin
    dreg_d  = din_en_n ? dreg_q : din;
    rd_d    = rd_word;
    match_d = tag_eq;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg_q  <= '0;
      rd_q    <= '0;
      match_q <= 1'b0;
    end else begin
      dreg_q  <= dreg_d;
      rd_q    <= rd_d;
      match_q <= match_d;
    end
  end

  assign dout       = rd_q;
  assign dout_valid = !oe_n && !wr_any;
  assign match      = match_q && !moe_n;

endmodule

// File: rtl/tag_match_ram_chk.sv
module tag_match_ram_chk #(
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe_n,
  input logic              moe_n,
  input logic              gw_n,
  input logic              din_en_n,
  input logic [WORD_W-1:0] dout,
  input logic              dout_valid,
  input logic              match,
  input logic              match_raw,
  input logic [WORD_W-1:0] dreg
);

  p_hold_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    din_en_n |=> (dreg == $past(dreg)));

  p_full_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !gw_n |=> (dout == $past(dreg)));

  p_match_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match_raw |-> (dout == $past(dreg)));

  p_match_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    moe_n |-> !match);

  p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || !gw_n) |-> !dout_valid);

endmodule

bind tag_match_ram tag_match_ram_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .oe_n       (oe_n),
  .moe_n      (moe_n),
  .gw_n       (gw_n),
  .din_en_n   (din_en_n),
  .dout       (dout),
  .dout_valid (dout_valid),
  .match      (match),
  .match_raw  (match_q),
  .dreg       (dreg_q)
);

// File: tb/tag_match_ram_test.sv
`timescale 1ns/1ps
module tag_match_ram_test;

  localparam int W = 18;
  localparam int D = 16;
  localparam int VW = 4 + W + 1 + 1 + 1 + 2;
  localparam int NV = 14;

  // fields: addr, din, din_en_n, gw_n, bw_n, lane_we_n
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2, 18'h2A5A5, 1'b0, 1'b1, 1'b1, 2'b11},  // load tag (R2)
    {4'd2, 18'h00000, 1'b1, 1'b1, 1'b0, 2'b10},  // low lane write (R4)
    {4'd2, 18'h00000, 1'b1, 1'b1, 1'b1, 2'b11},  // read back (R6)
    {4'd2, 18'h00000, 1'b1, 1'b1, 1'b0, 2'b01},  // high lane write (R4)
    {4'd2, 18'h00000, 1'b1, 1'b1, 1'b1, 2'b11},  // full match (R8)
    {4'd5, 18'h00000, 1'b1, 1'b1, 1'b1, 2'b00},  // lanes without gate (R5)
    {4'd5, 18'h00000, 1'b1, 1'b1, 1'b1, 2'b11},  // unchanged (R5)
    {4'd7, 18'h00000, 1'b1, 1'b0, 1'b0, 2'b11},  // full write wins (R3, R7)
    {4'd7, 18'h00000, 1'b1, 1'b1, 1'b1, 2'b11},  // compare after write (R7)
    {4'd7, 18'h15A3C, 1'b0, 1'b1, 1'b1, 2'b11},  // new tag (R2)
    {4'd7, 18'h00000, 1'b1, 1'b1, 1'b1, 2'b11},  // mismatch (R8)
    {4'd7, 18'h3FFFF, 1'b1, 1'b1, 1'b1, 2'b11},  // garbage ignored (R2)
    {4'd9, 18'h00000, 1'b1, 1'b0, 1'b1, 2'b11},  // full write (R3)
    {4'd9, 18'h00000, 1'b1, 1'b1, 1'b1, 2'b11}   // held tag stored (R2)
  };

  logic         clk, rst_n;
  logic [3:0]   addr;
  logic [W-1:0] din;
  logic         din_en_n, gw_n, bw_n, oe_n, moe_n;
  logic [1:0]   lane_we_n;
  logic [W-1:0] dout;
  logic         dout_valid, match;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [W-1:0] mem_m [D];
  logic [W-1:0] tag_m;
  logic [W-1:0] exp_dout;
  logic         exp_match;

  tag_match_ram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .din_en_n(din_en_n),
    .gw_n(gw_n), .bw_n(bw_n), .lane_we_n(lane_we_n), .oe_n(oe_n),
    .moe_n(moe_n), .dout(dout), .dout_valid(dout_valid), .match(match)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; applies inputs, models the edge, checks after it
  task automatic step(input logic [3:0] a, input logic [W-1:0] d,
                      input logic den, input logic g, input logic b,
                      input logic [1:0] l);
    logic [1:0] mask;
    logic       wr;
    addr = a; din = d; din_en_n = den; gw_n = g; bw_n = b; lane_we_n = l;
    @(posedge clk);
    mask = !g ? 2'b11 : (!b ? ~l : 2'b00);
    wr = (mask != 2'b00);
    if (mask[0]) mem_m[a][8:0]  = tag_m[8:0];
    if (mask[1]) mem_m[a][17:9] = tag_m[17:9];
    exp_dout  = mem_m[a];
    exp_match = (tag_m == exp_dout);
    if (!den) tag_m = d;
    @(negedge clk);
    chk(dout === exp_dout, "R6/R7 dout", dout, exp_dout);
    chk(match === (exp_match && !moe_n), "R8 match", 18'(match), 18'(exp_match));
    chk(dout_valid === (!oe_n && !wr), "R10 dout_valid", 18'(dout_valid),
        18'(!oe_n && !wr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; din = '0; din_en_n = 1'b1; gw_n = 1'b1;
    bw_n = 1'b1; lane_we_n = 2'b11; oe_n = 1'b0; moe_n = 1'b0;
    tag_m = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dout === '0, "R1 dout in reset", dout, '0);
    chk(match === 1'b0, "R1 match in reset", 18'(match), 18'd0);
    rst_n = 1'b1;
    chk(dout === '0, "R1 dout after release", dout, '0);

    // preload every word with a distinct pattern through full writes
    for (int a = 0; a < D; a++) begin
      step(4'(a), 18'(a * 18'h02345 + 7), 1'b0, 1'b1, 1'b1, 2'b11);
      step(4'(a), '0, 1'b1, 1'b0, 1'b1, 2'b11);
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][VW-1 -: 4], VEC[i][VW-5 -: W], VEC[i][4], VEC[i][3],
           VEC[i][2], VEC[i][1:0]);
    end

    // R9: match gated asynchronously (last vector left a match of 1)
    chk(match === 1'b1, "R9 match enabled", 18'(match), 18'd1);
    moe_n = 1'b1; #0.5;
    chk(match === 1'b0, "R9 match gated", 18'(match), 18'd0);
    moe_n = 1'b0; #0.5;
    chk(match === 1'b1, "R9 match restored", 18'(match), 18'd1);

    // R10: output enable and byte write gate valid without a clock
    oe_n = 1'b1; #0.5;
    chk(dout_valid === 1'b0, "R10 oe off", 18'(dout_valid), 18'd0);
    oe_n = 1'b0; bw_n = 1'b0; lane_we_n = 2'b01; #0.5;
    chk(dout_valid === 1'b0, "R10 byte write active", 18'(dout_valid), 18'd0);
    lane_we_n = 2'b11; #0.5;
    chk(dout_valid === 1'b1, "R10 gate without lanes", 18'(dout_valid), 18'd1);
    bw_n = 1'b1;
    @(negedge clk);

    // R4: both lanes in one byte write, then compare
    step(4'd11, 18'h0F0F0, 1'b0, 1'b1, 1'b1, 2'b11);
    step(4'd11, '0, 1'b1, 1'b1, 1'b0, 2'b00);
    step(4'd11, '0, 1'b1, 1'b1, 1'b1, 2'b11);
    chk(match === 1'b1, "R4 both lanes match", 18'(match), 18'd1);

    // R1: reset in mid-run
    rst_n = 1'b0; #0.5;
    chk(dout === '0, "R1 dout mid-run reset", dout, '0);
    chk(match === 1'b0, "R1 match mid-run reset", 18'(match), 18'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule